// File: doc/BRIEF.md
# Five-Operand Modular Adder with Column Counters

This block sums five unsigned W-bit operands and presents the total modulo 2^W on a registered output. Each operand bus enters a combinational reduction network, and the result is captured on the next rising clock edge. Any carry that would leave bit W-1 is dropped.

The reduction does not chain 3:2 carry-save cells over the operands. In the default column style, every bit position feeds a 5-to-3 population counter. The counter outputs form three rows, which are shifted by zero, one and two places. One carry-save level folds these rows into two, and a ripple-carry adder produces the final word. A build-time option changes to a pair style. In that style, each pair of adjacent columns goes into one two-column counter, whose four-bit count can reach 15. The four count bits form two non-overlapping rows, so the carry-save level disappears and only the ripple adder remains. The pair style needs an even W.

Top module: `fiveop_sum`

## Requirements
- R1: One clock edge after a set of operands is sampled, `sum_q` equals (op_a + op_b + op_c + op_d + op_e) mod 2^W.
- R2: When bit i is set in all five operands and every other bit is clear, `sum_q` equals 5·2^i mod 2^W. This holds at every position i, including the top two columns, where the counter's upper outputs fall outside the word.
- R3: When all five operands are all ones, `sum_q` equals 2^W − 5. All carries beyond bit W-1 are discarded.
- R4: The pair style (MODE = 1) gives the same `sum_q` as the column style for every input. This includes the case where both columns of a pair are full in all five operands (count 15), which gives 15·2^(2p) mod 2^W.
- R5: Driving `rst_n` low clears `sum_q` to zero at once, without waiting for a clock edge. `sum_q` stays zero until the first rising edge after `rst_n` returns high.
- R6: When all operands are zero, `sum_q` is zero on the following cycle.
- R7: When the operands are held unchanged across consecutive edges, `sum_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `sum_q` updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the bench releases it away from the clock edge |
| op_a | input | W | Operand 1 |
| op_b | input | W | Operand 2 |
| op_c | input | W | Operand 3 |
| op_d | input | W | Operand 4 |
| op_e | input | W | Operand 5 |
| sum_q | output | W | Registered sum of the five operands modulo 2^W |

## Verification
The bench builds four copies of the block:
- W = 3 in the column style. Every one of the 32768 operand combinations is applied, so every counter value in every column and every truncated top column is covered.
- W = 16 in both styles. Random and directed operands are applied, including all-ones words and single full columns at each position.
- W = 4 in the pair style. Here the top pair has no room for its upper count bits, which brings the truncated two-column counter within reach.

A mid-run asynchronous reset checks that the output clears without a clock edge.

// File: rtl/fiveop_pkg.sv
package fiveop_pkg;
  // reduction style selectors for the MODE parameter
  localparam int MODE_COLUMN = 0;
  localparam int MODE_PAIR   = 1;

  // number of operands entering each column
  localparam int NUM_OPS = 5;

  // width of a single-column count that still lands inside a W-bit word
  function automatic int col_out_bits(input int w, input int col);
    return ((w - col) >= 3) ? 3 : (w - col);
  endfunction

  // width of a two-column count that still lands inside a W-bit word
  function automatic int pair_out_bits(input int w, input int low_col);
    return ((w - low_col) >= 4) ? 4 : (w - low_col);
  endfunction
endpackage

// File: rtl/col_counter.sv
module col_counter #(
  parameter int OB = 3
) (
  input  logic [4:0]    bits,
  output logic [OB-1:0] count
);
  // population count of five equal-weight bits, kept modulo 2^OB
  always_comb begin
    count = '0;
    for (int k = 0; k < 5; k++) begin
      count = count + OB'(bits[k]);
    end
  end
endmodule

// File: rtl/pair_counter.sv
module pair_counter #(
  parameter int OB = 4
) (
  input  logic [4:0]    bits_lo,
  input  logic [4:0]    bits_hi,
  output logic [OB-1:0] count
);
  // weighted count: upper-column bits carry weight two, result modulo 2^OB
  always_comb begin
    count = '0;
    for (int k = 0; k < 5; k++) begin
      count = count + OB'(bits_lo[k]) + (OB'(bits_hi[k]) << 1);
    end
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  // carry_o is already shifted up one place; the carry out of bit W-1 is never formed
  assign sum_o      = in_a ^ in_b ^ in_c;
  assign carry_o[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_maj
    assign carry_o[i] = (in_a[i-1] & in_b[i-1]) | (in_a[i-1] & in_c[i-1]) |
                        (in_b[i-1] & in_c[i-1]);
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] sum
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = in_a[i] ^ in_b[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (in_a[i] & in_b[i]) | (cy[i] & (in_a[i] ^ in_b[i]));
    end
  end
endmodule

// File: rtl/column_stage.sv
module column_stage
  import fiveop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_e,
  output logic [W-1:0] row_x,
  output logic [W-1:0] row_y
);
  logic [W-1:0] r_w0;  // count bit 0, weight 2^i
  logic [W-1:0] r_w1;  // count bit 1, landing at i+1
  logic [W-1:0] r_w2;  // count bit 2, landing at i+2

  if (W < 3) begin : g_width_check
    $error("column_stage needs W of at least 3");
  end

  assign r_w1[0]   = 1'b0;
  assign r_w2[1:0] = 2'b00;

  for (genvar i = 0; i < W; i++) begin : g_col
    localparam int OB = col_out_bits(W, i);
    logic [OB-1:0] cnt;

    col_counter #(.OB(OB)) u_cnt (
      .bits  ({op_e[i], op_d[i], op_c[i], op_b[i], op_a[i]}),
      .count (cnt)
    );

    assign r_w0[i] = cnt[0];
    if (OB > 1) begin : g_b1
      assign r_w1[i+1] = cnt[1];
    end
    if (OB > 2) begin : g_b2
      assign r_w2[i+2] = cnt[2];
    end
  end

  csa_row #(.W(W)) u_csa (
    .in_a    (r_w0),
    .in_b    (r_w1),
    .in_c    (r_w2),
    .sum_o   (row_x),
    .carry_o (row_y)
  );
endmodule

// File: rtl/pair_stage.sv
module pair_stage
  import fiveop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_e,
  output logic [W-1:0] row_lo,
  output logic [W-1:0] row_hi
);
  localparam int NPAIR = W / 2;

  if ((W % 2) != 0 || W < 2) begin : g_width_check
    $error("pair_stage needs a positive even W");
  end

  assign row_hi[1:0] = 2'b00;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int LC = 2 * p;
    localparam int OB = pair_out_bits(W, LC);
    logic [OB-1:0] cnt;

    pair_counter #(.OB(OB)) u_cnt (
      .bits_lo ({op_e[LC],   op_d[LC],   op_c[LC],   op_b[LC],   op_a[LC]}),
      .bits_hi ({op_e[LC+1], op_d[LC+1], op_c[LC+1], op_b[LC+1], op_a[LC+1]}),
      .count   (cnt)
    );

    // low two count bits stay in their own pair; high two move up one pair
    assign row_lo[LC]   = cnt[0];
    assign row_lo[LC+1] = cnt[1];
    if (OB > 2) begin : g_up
      assign row_hi[LC+2] = cnt[2];
      assign row_hi[LC+3] = cnt[3];
    end
  end
endmodule

// File: rtl/fiveop_sum.sv
module fiveop_sum
  import fiveop_pkg::*;
#(
  parameter int W    = 16,
  parameter int MODE = MODE_COLUMN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_e,
  output logic [W-1:0] sum_q
);
  logic [W-1:0] row_x;
  logic [W-1:0] row_y;
  logic [W-1:0] sum_raw;
  logic [W-1:0] sum_d;

  if (MODE == MODE_PAIR) begin : g_pair
    pair_stage #(.W(W)) u_stage (
      .op_a   (op_a),
      .op_b   (op_b),
      .op_c   (op_c),
      .op_d   (op_d),
      .op_e   (op_e),
      .row_lo (row_x),
      .row_hi (row_y)
    );
  end else begin : g_column
    column_stage #(.W(W)) u_stage (
      .op_a  (op_a),
      .op_b  (op_b),
      .op_c  (op_c),
      .op_d  (op_d),
      .op_e  (op_e),
      .row_x (row_x),
      .row_y (row_y)
    );
  end

  ripple_add #(.W(W)) u_cpa (
    .in_a (row_x),
    .in_b (row_y),
    .sum  (sum_raw)
  );

  // next-state
  always_comb begin
    sum_d = sum_raw;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end
endmodule

// File: rtl/fiveop_sum_chk.sv
module fiveop_sum_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic [W-1:0] op_d,
  input logic [W-1:0] op_e,
  input logic [W-1:0] sum_q
);
  logic [W-1:0] ref_sum;
  logic         run1;
  logic         run2;
  logic         all_ones;
  logic         all_zero;

  assign ref_sum  = op_a + op_b + op_c + op_d + op_e;
  assign all_ones = (&op_a) & (&op_b) & (&op_c) & (&op_d) & (&op_e);
  assign all_zero = ~(|{op_a, op_b, op_c, op_d, op_e});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run1 <= 1'b0;
      run2 <= 1'b0;
    end else begin
      run1 <= 1'b1;
      run2 <= run1;
    end
  end

  AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    run1 |-> (sum_q == $past(ref_sum))); // R1

  AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (run1 && $past(all_ones)) |-> (sum_q == ({W{1'b1}} - W'(4)))); // R3

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (run1 && $past(all_zero)) |-> (sum_q == '0)); // R6

  AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run1 |-> (sum_q == '0)); // R5

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run2 && $past(ref_sum) == $past(ref_sum, 2) &&
     $past({op_a, op_b, op_c, op_d, op_e}) == $past({op_a, op_b, op_c, op_d, op_e}, 2))
    |-> $stable(sum_q)); // R7
endmodule

bind fiveop_sum fiveop_sum_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_a  (op_a),
  .op_b  (op_b),
  .op_c  (op_c),
  .op_d  (op_d),
  .op_e  (op_e),
  .sum_q (sum_q)
);

// File: tb/sim_fiveop_sum.sv
module sim_fiveop_sum;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [2:0]  op3  [5];
  logic [15:0] op16 [5];
  logic [3:0]  op4  [5];
  logic [2:0]  y3;
  logic [15:0] y16c;
  logic [15:0] y16p;
  logic [3:0]  y4;

  fiveop_sum #(.W(3), .MODE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op3[0]), .op_b(op3[1]), .op_c(op3[2]),
    .op_d(op3[3]), .op_e(op3[4]), .sum_q(y3));
  fiveop_sum #(.W(16), .MODE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .op_a(op16[0]), .op_b(op16[1]), .op_c(op16[2]),
    .op_d(op16[3]), .op_e(op16[4]), .sum_q(y16c));
  fiveop_sum #(.W(16), .MODE(1)) u2 (
    .clk(clk), .rst_n(rst_n), .op_a(op16[0]), .op_b(op16[1]), .op_c(op16[2]),
    .op_d(op16[3]), .op_e(op16[4]), .sum_q(y16p));
  fiveop_sum #(.W(4), .MODE(1)) u3 (
    .clk(clk), .rst_n(rst_n), .op_a(op4[0]), .op_b(op4[1]), .op_c(op4[2]),
    .op_d(op4[3]), .op_e(op4[4]), .sum_q(y4));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] q3 [$];
  logic [15:0] q16c [$];
  logic [15:0] q16p [$];
  logic [15:0] q4 [$];
  string       qtag [$];

  task automatic chk(input string tag, input string who, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, who, act, exp);
    end
  endtask

  function automatic logic [15:0] modsum(input logic [15:0] v [5], input int w);
    longint s = 0;
    for (int k = 0; k < 5; k++) s += longint'(v[k]);
    return 16'(s % (longint'(1) << w));
  endfunction

  // compare last cycle's results, then drive a new operand set and queue its expected sums
  task automatic step(input logic [15:0] v [5], input string tag);
    @(negedge clk);
    if (qtag.size() > 0) begin
      string t = qtag.pop_front();
      chk(t, "u0 W3 column", 16'(y3), q3.pop_front());
      chk(t, "u1 W16 column", y16c, q16c.pop_front());
      chk(t, "u2 W16 pair", y16p, q16p.pop_front());
      chk(t, "u3 W4 pair", 16'(y4), q4.pop_front());
    end
    for (int k = 0; k < 5; k++) begin
      op16[k] = v[k];
      op3[k]  = v[k][2:0];
      op4[k]  = v[k][3:0];
    end
    q3.push_back(modsum(v, 3));
    q16c.push_back(modsum(v, 16));
    q16p.push_back(modsum(v, 16));
    q4.push_back(modsum(v, 4));
    qtag.push_back(tag);
  endtask

  task automatic check_zero(input string tag);
    chk(tag, "u0", 16'(y3), 16'h0);
    chk(tag, "u1", y16c, 16'h0);
    chk(tag, "u2", y16p, 16'h0);
    chk(tag, "u3", 16'(y4), 16'h0);
  endtask

  task automatic flush_queues();
    q3.delete(); q16c.delete(); q16p.delete(); q4.delete(); qtag.delete();
  endtask

  initial begin
    logic [15:0] v [5];
    rst_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      op16[k] = 16'hA5C3; op3[k] = 3'h5; op4[k] = 4'hC;
    end
    repeat (3) @(negedge clk);
    check_zero("R5 reset");
    rst_n = 1'b1;
    #1;
    check_zero("R5 after release");

    // exhaustive W=3 on u0, random upper bits for the wider copies
    for (int n = 0; n < 32768; n++) begin
      for (int k = 0; k < 5; k++) begin
        v[k] = 16'($urandom);
        v[k][2:0] = 3'((n >> (3 * k)) & 7);
      end
      step(v, "R1 exhaustive/random");
    end

    // every operand all ones
    for (int k = 0; k < 5; k++) v[k] = 16'hFFFF;
    step(v, "R3 all ones");
    step(v, "R7 all ones held");
    step(v, "R7 all ones held again");

    // a single full column at each position
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 5; k++) v[k] = 16'(1) << i;
      step(v, "R2 single full column");
    end

    // both columns of each pair full (count 15)
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 5; k++) v[k] = 16'(3) << (2 * p);
      step(v, "R4 full column pair");
    end

    for (int k = 0; k < 5; k++) v[k] = 16'h0;
    step(v, "R6 all zero");

    for (int n = 0; n < 2000; n++) begin
      for (int k = 0; k < 5; k++) v[k] = 16'($urandom);
      step(v, "R4 random both styles");
    end

    // asynchronous reset in the middle of a run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check_zero("R5 async clear");
    flush_queues();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_zero("R5 held until edge");
    for (int n = 0; n < 50; n++) begin
      for (int k = 0; k < 5; k++) v[k] = 16'($urandom);
      step(v, "R1 after reset");
    end
    for (int k = 0; k < 5; k++) v[k] = 16'h0;
    step(v, "R6 all zero flush");
    step(v, "R6 all zero flush");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule